// File: doc/BRIEF.md
# Double-Buffered Transmit Byte Pool

This block sits between a host bus and a bit-serial transmitter. It holds two halves of `HALF_BYTES` bytes each. The host can reach only one of them, the fill half. It writes into it one byte or one 16-bit word at a time. The address it presents does not matter: each write goes to the next free position of the fill half. The other half, the drain half, is owned by a serializer. That serializer hands bits to the transmitter through a valid/take handshake, least-significant bit first.

After filling, the host issues a transmit command. Once the drain half has been fully sent, the two halves swap roles on a clock with no host write. The swap moves the filled bytes to the serializer in one step and reopens an empty fill half. The block then raises a one-cycle pool-ready pulse, so the host can start on the next batch while the previous one is still on the line.

A status byte reports whether the host may write (bit 6) and whether data was refused because the fill half was full (bit 7, sticky). A transmitter reset command discards everything in both halves.

Top module: `tx_pool_fifo`

## Requirements
- R1: After `rst`, `stat` reads 0x48: bit 7 (overflow) is 0, bit 6 (write enable) is 1, bit 3 is a constant 1 and all other bits are 0. `pool_irq` and `ser_valid` are low.
- R2: `host_addr` has no effect: every accepted write lands at the current fill position, whatever address is presented.
- R3: A byte write (`host_word`=0) appends `host_data[7:0]`. A word write (`host_word`=1) appends `host_data[7:0]` and then `host_data[15:8]`, so the low byte is transmitted first.
- R4: The fill half holds `HALF_BYTES` (32) bytes. `stat` bit 6 is 1 exactly while fewer than 32 bytes are stored.
- R5: A byte write with 32 bytes stored, or a word write with 31 or 32 bytes stored, stores nothing and sets `stat` bit 7. The bit stays set until R6 clears it.
- R6: `stat` bit 7 clears when the fill half is handed to the serializer, or on `tx_reset`.
- R7: A hand-over happens on a clock edge when all of these are true: a `tx_cmd` was sampled on an earlier edge, the drain half is empty, the fill half is not empty, and `host_wr` is low. It moves every stored byte and leaves the fill half empty. The pending command is consumed.
- R8: `pool_irq` is high for exactly the one cycle after each hand-over.
- R9: Bits leave on `ser_bit` least-significant bit first, bytes in write order. A bit is consumed on an edge where `ser_valid` and `ser_take` are both high, and it holds while not taken.
- R10: While the drain half is busy, the host may fill the other half and issue a command. The next hand-over waits until the last bit of the previous batch has been taken.
- R11: `tx_reset` empties both halves and clears the write position, the overflow bit, a pending command and a pending `pool_irq`. `ser_valid` is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_word | input | 1 | 1 = 16-bit write, 0 = byte write |
| host_addr | input | WIN_W | Window address, ignored for placement |
| host_data | input | 16 | Write data; low byte used for byte writes |
| tx_cmd | input | 1 | Transmit command pulse |
| tx_reset | input | 1 | Transmitter reset command |
| ser_take | input | 1 | Transmitter accepts the presented bit |
| ser_valid | output | 1 | A bit is presented on ser_bit |
| ser_bit | output | 1 | Serial data bit |
| pool_irq | output | 1 | One-cycle pulse after a hand-over |
| stat | output | 8 | Status: bit 7 overflow, bit 6 write enable, bit 3 fixed 1 |

## Verification
The properties rely on three things from the environment. `host_addr` is known whenever `host_wr` is high. `tx_cmd` and `tx_reset` are synchronous single-cycle strobes. The transmitter may withhold `ser_take` for any number of cycles. The bench drives every input at the falling edge and sweeps the address on each write. It runs the take strobe always high, never high (to hold a batch while the next one is filled) and in an irregular pattern. Writes overrun the fill half only at the 32- and 31-byte boundaries called out above.

// File: rtl/tpf_pkg.sv
`timescale 1ns/1ps
package tpf_pkg;
  typedef enum logic [1:0] {
    SER_IDLE,
    SER_FETCH,
    SER_LOAD,
    SER_SHIFT
  } ser_state_t;

  localparam logic [7:0] STAT_FIXED = 8'h08;
endpackage

// File: rtl/tpf_lane_ram.sv
`timescale 1ns/1ps
module tpf_lane_ram #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tpf_host_port.sv
`timescale 1ns/1ps
module tpf_host_port #(
  parameter int HALF  = 32,
  parameter int IDX_W = $clog2(HALF),
  parameter int CNT_W = IDX_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  move,
  input  logic                  wr_en,
  input  logic                  wr_word,
  input  logic [15:0]           wr_data,
  output logic [CNT_W-1:0]      fill,
  output logic                  ovf,
  output logic                  bank,
  output logic [1:0]            lane_we,
  output logic [1:0][IDX_W-1:0] lane_addr,
  output logic [1:0][7:0]       lane_data
);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] WORD_LIM = CNT_W'(HALF - 2);

  logic               take_b, take_w, refuse;
  logic [IDX_W-1:0]   pos0;
  logic [IDX_W-2:0]   row0, row1;

  assign take_b = wr_en && !flush && !wr_word && (fill < FULL);
  assign take_w = wr_en && !flush &&  wr_word && (fill <= WORD_LIM);
  assign refuse = wr_en && !flush && !take_b && !take_w;
  assign pos0   = fill[IDX_W-1:0];
  assign row0   = pos0[IDX_W-1:1];
  assign row1   = pos0[IDX_W-1:1] + (IDX_W-1)'(pos0[0]);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic is_first;
    assign is_first     = (pos0[0] == 1'(g));
    assign lane_we[g]   = is_first ? (take_b || take_w) : take_w;
    assign lane_addr[g] = is_first ? {bank, row0} : {bank, row1};
    assign lane_data[g] = is_first ? wr_data[7:0] : wr_data[15:8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill <= '0;
      ovf  <= 1'b0;
      bank <= 1'b0;
    end else if (flush) begin
      fill <= '0;
      ovf  <= 1'b0;
    end else if (move) begin
      fill <= '0;
      ovf  <= 1'b0;
      bank <= ~bank;
    end else begin
      if (take_b)      fill <= fill + CNT_W'(1);
      else if (take_w) fill <= fill + CNT_W'(2);
      if (refuse)      ovf  <= 1'b1;
    end
  end

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill <= FULL);
  // R5
  word_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_word && !flush && fill > WORD_LIM) |=> (ovf && $stable(fill)));
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !flush && !move) |=> ovf);
  // R6
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (move || flush) |=> !ovf);
endmodule

// File: rtl/tpf_serializer.sv
`timescale 1ns/1ps
module tpf_serializer
  import tpf_pkg::*;
#(
  parameter int HALF  = 32,
  parameter int IDX_W = $clog2(HALF),
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             start,
  input  logic             start_bank,
  input  logic [CNT_W-1:0] start_len,
  input  logic [1:0][7:0]  lane_q,
  output logic [IDX_W-1:0] rd_addr,
  output logic             idle,
  input  logic             ser_take,
  output logic             ser_valid,
  output logic             ser_bit
);
  ser_state_t       state;
  logic             sbank;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] left;
  logic [7:0]       sh;
  logic [2:0]       bitn;

  assign rd_addr   = {sbank, idx[IDX_W-1:1]};
  assign idle      = (state == SER_IDLE);
  assign ser_valid = (state == SER_SHIFT);
  assign ser_bit   = sh[0];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state <= SER_IDLE;
      sbank <= 1'b0;
      idx   <= '0;
      left  <= '0;
      sh    <= '0;
      bitn  <= '0;
    end else begin
      case (state)
        SER_IDLE: if (start) begin
          sbank <= start_bank;
          idx   <= '0;
          left  <= start_len;
          state <= SER_FETCH;
        end
        SER_FETCH: state <= SER_LOAD;
        SER_LOAD: begin
          sh    <= lane_q[idx[0]];
          bitn  <= '0;
          idx   <= idx + IDX_W'(1);
          left  <= left - CNT_W'(1);
          state <= SER_SHIFT;
        end
        default: if (ser_take) begin
          sh   <= {1'b0, sh[7:1]};
          bitn <= bitn + 3'd1;
          if (bitn == 3'd7) state <= (left != '0) ? SER_FETCH : SER_IDLE;
        end
      endcase
    end
  end

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> idle);
  // R9
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_valid && !ser_take && !flush) |=> (ser_valid && $stable(ser_bit)));
  // R11
  flush_idle_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (idle && !ser_valid));
endmodule

// File: rtl/tx_pool_fifo.sv
`timescale 1ns/1ps
module tx_pool_fifo
  import tpf_pkg::*;
#(
  parameter int HALF_BYTES = 32,
  parameter int WIN_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic             host_word,
  input  logic [WIN_W-1:0] host_addr,
  input  logic [15:0]      host_data,
  input  logic             tx_cmd,
  input  logic             tx_reset,
  input  logic             ser_take,
  output logic             ser_valid,
  output logic             ser_bit,
  output logic             pool_irq,
  output logic [7:0]       stat
);
  localparam int IDX_W = $clog2(HALF_BYTES);
  localparam int CNT_W = IDX_W + 1;

  logic                  pend, move, ser_idle, ovf, bank;
  logic [CNT_W-1:0]      fill;
  logic [1:0]            lane_we;
  logic [1:0][IDX_W-1:0] lane_addr;
  logic [1:0][7:0]       lane_data;
  logic [1:0][7:0]       lane_q;
  logic [IDX_W-1:0]      rd_addr;

  assign move = pend && ser_idle && (fill != '0) && !host_wr && !tx_reset;
  assign stat = {ovf, (fill < CNT_W'(HALF_BYTES)), STAT_FIXED[5:0]};

  always_ff @(posedge clk) begin
    if (rst || tx_reset) begin
      pend     <= 1'b0;
      pool_irq <= 1'b0;
    end else begin
      pool_irq <= move;
      if (move)        pend <= 1'b0;
      else if (tx_cmd) pend <= 1'b1;
    end
  end

  tpf_host_port #(.HALF(HALF_BYTES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_host (
    .clk(clk), .rst(rst), .flush(tx_reset), .move(move),
    .wr_en(host_wr), .wr_word(host_word), .wr_data(host_data),
    .fill(fill), .ovf(ovf), .bank(bank),
    .lane_we(lane_we), .lane_addr(lane_addr), .lane_data(lane_data)
  );

  for (genvar g = 0; g < 2; g++) begin : g_ram
    tpf_lane_ram #(.DEPTH(HALF_BYTES)) u_lane (
      .clk(clk), .we(lane_we[g]), .waddr(lane_addr[g]), .wdata(lane_data[g]),
      .raddr(rd_addr), .rdata(lane_q[g])
    );
  end

  tpf_serializer #(.HALF(HALF_BYTES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ser (
    .clk(clk), .rst(rst), .flush(tx_reset), .start(move),
    .start_bank(bank), .start_len(fill), .lane_q(lane_q),
    .rd_addr(rd_addr), .idle(ser_idle),
    .ser_take(ser_take), .ser_valid(ser_valid), .ser_bit(ser_bit)
  );

  // R2
  addr_known_chk: assert property (@(posedge clk) disable iff (rst)
    host_wr |-> !$isunknown(host_addr));
  // R8
  irq_after_move_chk: assert property (@(posedge clk) disable iff (rst)
    (move && !tx_reset) |=> pool_irq);
  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    pool_irq |=> !pool_irq);
  // R7
  fill_empty_after_move_chk: assert property (@(posedge clk) disable iff (rst)
    move |=> (fill == '0 && !ser_idle));
endmodule

// File: tb/tb_tx_pool_fifo.sv
`timescale 1ns/1ps
module tb_tx_pool_fifo;
  logic clk = 1'b0, rst = 1'b1;
  logic host_wr = 0, host_word = 0, tx_cmd = 0, tx_reset = 0, ser_take = 0;
  logic [4:0]  host_addr = '0;
  logic [15:0] host_data = '0;
  logic ser_valid, ser_bit, pool_irq;
  logic [7:0] stat;

  tx_pool_fifo dut (.*);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, cyc_n = 0, take_mode = 1;
  bit done = 0;
  logic [7:0] acc_q[$];
  bit bit_q[$];
  bit pend_m = 0, ovf_m = 0, irq_m = 0;
  logic [4:0] addr_ctr = 5'd3;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%02h expected=%02h (cycle %0d)", tag, act, exp, cyc_n);
    end
  endtask

  task automatic cyc(input bit wr, input bit word, input logic [7:0] d0, input logic [7:0] d1,
                     input bit cmd, input bit xr);
    bit popped, pre_empty, mv, tk;
    logic [7:0] exp_stat;
    @(negedge clk);
    cyc_n++;
    tk = (take_mode == 1) ? 1'b1 : (take_mode == 0) ? 1'b0 : ((cyc_n % 3) != 1);
    exp_stat = {ovf_m, (acc_q.size() < 32), 6'h08};
    chk(stat === exp_stat, "R1 R4 R5 R6 stat", stat, exp_stat);
    chk(pool_irq === irq_m, "R8 pool_irq", 8'(pool_irq), 8'(irq_m));
    if (bit_q.size() == 0) chk(ser_valid === 1'b0, "R11 ser_valid idle", 8'(ser_valid), 8'h00);
    popped = 0;
    if (ser_valid === 1'b1 && tk) begin
      if (bit_q.size() == 0) chk(1'b0, "R9 stray bit", 8'h01, 8'h00);
      else begin
        chk(ser_bit === bit_q[0], "R9 bit order", 8'(ser_bit), 8'(bit_q[0]));
        popped = 1;
      end
    end
    host_wr = wr; host_word = word; host_data = {d1, d0};
    host_addr = addr_ctr; addr_ctr = addr_ctr + 5'd7;
    tx_cmd = cmd; tx_reset = xr; ser_take = tk;
    pre_empty = (bit_q.size() == 0);
    if (popped) void'(bit_q.pop_front());
    if (xr) begin
      acc_q.delete(); bit_q.delete();
      pend_m = 0; ovf_m = 0; irq_m = 0;
    end else begin
      mv = pend_m && pre_empty && (acc_q.size() > 0) && !wr;
      irq_m = mv;
      if (mv) begin
        foreach (acc_q[i]) for (int b = 0; b < 8; b++) bit_q.push_back(acc_q[i][b]);
        acc_q.delete();
        ovf_m = 0; pend_m = 0;
      end else begin
        pend_m = pend_m | cmd;
        if (wr && !word) begin
          if (acc_q.size() < 32) acc_q.push_back(d0); else ovf_m = 1;
        end else if (wr && word) begin
          if (acc_q.size() <= 30) begin acc_q.push_back(d0); acc_q.push_back(d1); end
          else ovf_m = 1;
        end
      end
    end
  endtask

  task automatic wb(input logic [7:0] d);                 cyc(1, 0, d, 8'h00, 0, 0); endtask
  task automatic ww(input logic [7:0] lo, input logic [7:0] hi); cyc(1, 1, lo, hi, 0, 0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0); endtask
  task automatic cmd();                                    cyc(0, 0, 0, 0, 1, 0); endtask
  task automatic xres();                                   cyc(0, 0, 0, 0, 0, 1); endtask
  task automatic drain();
    for (int i = 0; i < 4000; i++) begin
      if (bit_q.size() == 0 && (acc_q.size() == 0 || !pend_m)) break;
      idle(1);
    end
    idle(3);
    chk(bit_q.size() == 0, "R9 R10 drained", 8'(bit_q.size()), 8'h00);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    idle(2);
    // R2 R3 R7 R8 R9: plain bytes, any address
    take_mode = 1;
    for (int i = 0; i < 5; i++) wb(8'(i * 37 + 5));
    cmd(); drain();
    // R3: mixed byte/word alignment, irregular take
    take_mode = 2;
    wb(8'hA1); ww(8'h12, 8'h34); ww(8'h56, 8'h78); wb(8'hC3); ww(8'h9A, 8'hBC);
    cmd(); drain();
    // R4 R5 R6: fill to 32, overrun with byte then word, hand-over clears
    take_mode = 1;
    for (int i = 0; i < 32; i++) wb(8'(i * 11 + 1));
    wb(8'hEE); ww(8'hDD, 8'hCC); idle(2);
    cmd(); drain();
    // R5: word refused at 31 stored, byte still accepted
    for (int i = 0; i < 31; i++) wb(8'(i * 5 + 2));
    ww(8'h55, 8'hAA); wb(8'h7E); wb(8'h7F); idle(1);
    cmd(); drain();
    // R10: second batch waits for the first to drain
    take_mode = 0;
    for (int i = 0; i < 4; i++) wb(8'(i + 8'hF0));
    cmd(); idle(4);
    for (int i = 0; i < 6; i++) ww(8'(i * 3), 8'(i * 3 + 1));
    cmd(); idle(10);
    take_mode = 1; drain();
    // R7: writes keep arriving while a command waits
    for (int i = 0; i < 3; i++) wb(8'(i + 8'h40));
    cmd();
    for (int i = 0; i < 3; i++) wb(8'(i + 8'h50));
    drain();
    // R11: reset mid-stream with overflow and pending command
    take_mode = 2;
    for (int i = 0; i < 8; i++) wb(8'(i * 29));
    cmd(); idle(20);
    for (int i = 0; i < 32; i++) wb(8'(i));
    wb(8'h01); cmd();
    xres(); idle(4);
    // R11: pool_irq pending when reset arrives
    wb(8'h66); cmd(); idle(2); xres(); idle(3);
    // normal operation afterwards
    take_mode = 1;
    ww(8'h3C, 8'hC3); cmd(); drain();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R9 watchdog: actual=timeout expected=finished");
      summary();
      $finish;
    end
  end
endmodule